// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the shifting core of a serial peripheral interface master. A host starts a transfer by pulsing a write strobe with a byte while the engine is idle. The engine then produces eight SCK pulses from a prescaled system clock, drives the byte out on SDO with the most significant bit first, and collects eight bits from SDI in the same order. When the eighth bit time ends, the received byte appears on `rx_data` and a buffer-full flag is raised. The host clears that flag by pulsing a read strobe.

Three configuration inputs shape the waveform. `cfg_cpol` sets the level SCK rests at between transfers. `cfg_cke` picks the SCK edge on which SDO is stable. `cfg_smp` moves the SDI capture point from the middle of each bit's output time to its end. Each bit lasts two SCK half-periods of H system clocks, where H is `div_half` (a value of 0 counts as 1). The full SCK period is therefore an even divisor of at least 2.

If a second byte arrives while the flag is still set, the new byte replaces the old one and a sticky overflow flag is set.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, `busy`, `buf_full`, `overflow`, `sdo` and `rx_data` are 0 and `sck` equals `cfg_cpol`.
- R2: A `tx_we` pulse while `busy` is 0 raises `busy` at that clock edge. From then on `sdo` carries `tx_data` MSB first, and each bit is held for exactly 2*H system clocks, where H = `div_half`, or 1 when `div_half` is 0.
- R3: Outside a transfer `sck` rests at `cfg_cpol`. Within each bit time the first H clocks and the last H clocks each hold one SCK level. With `cfg_cke`=1, `sck` sits at the idle level in the first half and at the opposite level in the second half, so data is stable on the first SCK edge of the bit. With `cfg_cke`=0, the order is reversed. `sck` changes only at half-period boundaries.
- R4: With `cfg_smp`=0, SDI is captured at the clock edge that ends the first half of each bit time. With `cfg_smp`=1, it is captured at the edge that ends the bit time.
- R5: At the edge that ends the eighth bit time (16*H clocks after the start edge), `busy` falls. At the same edge `rx_data` takes the eight captured bits, the first captured bit in bit 7, and `buf_full` is set.
- R6: An `rx_rd` pulse clears `buf_full` at the next edge and leaves `rx_data` unchanged. A completion in the same cycle as `rx_rd` keeps `buf_full` set.
- R7: A completion while `buf_full` is 1 and `rx_rd` is 0 sets `overflow`. `overflow` then stays 1 until reset, and `rx_data` takes the new byte.
- R8: A `tx_we` pulse while `busy` is 1 is ignored. The running byte, its timing and the received byte are unaffected, and no extra transfer follows.
- R9: `cfg_cke`, `cfg_smp` and `div_half` are taken at the start of a transfer. Changing them while `busy` is 1 has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cke | input | 1 | Data-stable edge select |
| cfg_smp | input | 1 | SDI capture point: 0 mid-bit, 1 end of bit |
| div_half | input | DW | SCK half-period in system clocks (0 counts as 1) |
| tx_we | input | 1 | Write strobe that starts a transfer |
| tx_data | input | NB | Byte to transmit |
| rx_rd | input | 1 | Read strobe that clears the buffer-full flag |
| rx_data | output | NB | Last received byte |
| buf_full | output | 1 | Received byte not yet read |
| overflow | output | 1 | Sticky: a byte completed over an unread one |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume `cfg_cpol` is held steady whenever a transfer is running, because the idle level is followed live and is not latched. The random stimulus only changes the configuration between transfers. The exception is the directed R9 runs, which deliberately alter the latched controls mid-transfer and leave `cfg_cpol` alone. The bench drives SDI with different bits in the two halves of each bit time, so any mix-up between the mid-bit and end-of-bit capture points changes the received byte.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int NB = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cke,
  input  logic          cfg_smp,
  input  logic [DW-1:0] div_half,
  input  logic          tx_we,
  input  logic [NB-1:0] tx_data,
  input  logic          rx_rd,
  output logic [NB-1:0] rx_data,
  output logic          buf_full,
  output logic          overflow,
  output logic          busy,
  output logic          sck,
  output logic          sdo,
  input  logic          sdi
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BW-1:0] LASTBIT = BW'(NB - 1);

  logic          busy_q, half_q, samp_q, cke_q, smp_q, full_q, ovf_q;
  logic [DW-1:0] hcnt_q, hl_q;
  logic [BW-1:0] bitn_q;
  logic [NB-1:0] sh_q, rxb_q;

  wire [DW-1:0] hl_in    = (div_half == '0) ? '0 : div_half - 1'b1;
  wire          start    = tx_we && !busy_q;
  wire          half_end = busy_q && (hcnt_q == hl_q);
  wire          bit_end  = half_end && half_q;
  wire          last     = bit_end && (bitn_q == LASTBIT);
  wire          in_bit   = smp_q ? sdi : samp_q;
  wire [NB-1:0] sh_nx    = {sh_q[NB-2:0], in_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      hcnt_q <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      samp_q <= 1'b0;
      cke_q  <= 1'b0;
      smp_q  <= 1'b0;
      hl_q   <= '0;
      rxb_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      half_q <= 1'b0;
      hcnt_q <= '0;
      bitn_q <= '0;
      sh_q   <= tx_data;
      cke_q  <= cfg_cke;
      smp_q  <= cfg_smp;
      hl_q   <= hl_in;
    end else if (busy_q) begin
      if (half_end) begin
        hcnt_q <= '0;
        half_q <= ~half_q;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
      if (half_end && !half_q) samp_q <= sdi;
      if (bit_end) begin
        sh_q   <= sh_nx;
        bitn_q <= bitn_q + 1'b1;
      end
      if (last) begin
        busy_q <= 1'b0;
        rxb_q  <= sh_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (last)       full_q <= 1'b1;
      else if (rx_rd) full_q <= 1'b0;
      if (last && full_q && !rx_rd) ovf_q <= 1'b1;
    end
  end

  assign busy     = busy_q;
  assign buf_full = full_q;
  assign overflow = ovf_q;
  assign rx_data  = rxb_q;
  assign sdo      = busy_q & sh_q[NB-1];
  assign sck      = cfg_cpol ^ (busy_q & (cke_q ? half_q : ~half_q));

  // R2
  sdo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sdo != $past(sdo))) |-> $past(bit_end));

  // R3
  sck_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sck != $past(sck))) |-> $past(half_end));

  // R3
  cpol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(cfg_cpol));

  // R5
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> buf_full);

  // R5
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $fell(busy));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);

  // R8
  bit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bitn_q >= $past(bitn_q)));
endmodule

// File: tb/tb_spi_shift_master.sv
module tb_spi_shift_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cke = 1'b0, cfg_smp = 1'b0;
  logic [7:0] div_half = 8'd1;
  logic       tx_we = 1'b0, rx_rd = 1'b0, sdi = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic [7:0] rx_data;
  logic       buf_full, overflow, busy, sck, sdo;

  int checks = 0, fails = 0, cyc = 0;
  bit exp_full = 1'b0, exp_ovf = 1'b0;
  logic [7:0] exp_rx = 8'd0;

  always #4 clk = ~clk;

  spi_shift_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cke(cfg_cke),
    .cfg_smp(cfg_smp), .div_half(div_half), .tx_we(tx_we), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .buf_full(buf_full), .overflow(overflow),
    .busy(busy), .sck(sck), .sdo(sdo), .sdi(sdi));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int half_len(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic bit exp_sck(input bit pol, input bit cke, input int j, input int h);
    bit second = (j % (2*h)) >= h;
    return pol ^ (cke ? second : ~second);
  endfunction

  function automatic logic [7:0] exp_byte(input bit smp, input logic [7:0] a, input logic [7:0] b);
    return smp ? b : a;
  endfunction

  task automatic status(input string tag);
    chk(busy == 1'b0, {tag, " busy"}, busy, 0);
    chk(buf_full == exp_full, {tag, " buf_full"}, buf_full, exp_full);
    chk(overflow == exp_ovf, {tag, " overflow"}, overflow, exp_ovf);
    chk(rx_data == exp_rx, {tag, " rx_data"}, rx_data, exp_rx);
    chk(sck == cfg_cpol, {tag, " idle sck"}, sck, cfg_cpol);
  endtask

  // perturb: 1 = R8 write during busy, 2 = R9 config change during busy
  task automatic xfer(input bit pol, input bit cke, input bit smp, input logic [7:0] dh,
                      input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                      input int perturb, input bit read_after);
    int h = half_len(dh);
    @(negedge clk);
    cfg_cpol = pol; cfg_cke = cke; cfg_smp = smp; div_half = dh;
    tx_data = tx; tx_we = 1'b1;
    for (int j = 0; j <= 16*h; j++) begin
      @(negedge clk);
      tx_we = 1'b0;
      if (j < 16*h) begin
        chk(busy == 1'b1, "R2 busy high", busy, 1);
        chk(sdo == tx[7 - j/(2*h)], "R2 sdo bit", sdo, tx[7 - j/(2*h)]);
        chk(sck == exp_sck(pol, cke, j, h), "R3 sck level", sck, exp_sck(pol, cke, j, h));
        sdi = ((j % (2*h)) < h) ? a[7 - j/(2*h)] : b[7 - j/(2*h)];
        if (perturb == 1 && j == 3) begin tx_we = 1'b1; tx_data = ~tx; end
        if (perturb == 2 && j == 1) begin cfg_cke = ~cke; cfg_smp = ~smp; div_half = dh + 8'd2; end
      end else begin
        if (exp_full) exp_ovf = 1'b1;
        exp_full = 1'b1;
        exp_rx = exp_byte(smp, a, b);
        chk(busy == 1'b0, "R5 busy falls", busy, 0);
        chk(buf_full == 1'b1, "R5 buf_full set", buf_full, 1);
        chk(rx_data == exp_rx, smp ? "R4 R5 rx end sample" : "R4 R5 rx mid sample", rx_data, exp_rx);
        chk(overflow == exp_ovf, "R7 overflow", overflow, exp_ovf);
        chk(sck == pol, "R3 sck idle after", sck, pol);
      end
    end
    cfg_cke = cke; cfg_smp = smp; div_half = dh;
    if (perturb == 1) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R8 no extra transfer", busy, 0);
    end
    if (read_after) begin
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      exp_full = 1'b0;
      chk(buf_full == 1'b0, "R6 read clears", buf_full, 0);
      chk(rx_data == exp_rx, "R6 rx_data kept", rx_data, exp_rx);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state (with cpol 1 to see idle follow)
    cfg_cpol = 1'b1;
    #1;
    status("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status("R1 after reset");

    // directed: all four clock modes, both sample points
    xfer(0, 1, 0, 8'd1, 8'hA5, 8'h3C, 8'hC3, 0, 1);
    xfer(0, 0, 1, 8'd2, 8'h5A, 8'h3C, 8'hC3, 0, 1);
    xfer(1, 1, 1, 8'd0, 8'hF0, 8'h81, 8'h7E, 0, 1);
    xfer(1, 0, 0, 8'd3, 8'h0F, 8'h81, 8'h7E, 0, 1);
    // R8 write while busy ignored
    xfer(0, 1, 1, 8'd2, 8'h96, 8'h12, 8'h34, 1, 1);
    // R9 config change mid-transfer ignored
    xfer(1, 1, 0, 8'd1, 8'h69, 8'hAB, 8'hCD, 2, 1);
    // R7 overflow: two transfers without read, second byte kept
    xfer(0, 0, 0, 8'd1, 8'h11, 8'h22, 8'h44, 0, 0);
    xfer(0, 0, 1, 8'd1, 8'h33, 8'h55, 8'h66, 0, 0);
    status("R7 sticky idle");
    xfer(0, 1, 0, 8'd2, 8'h77, 8'h88, 8'h99, 0, 1);
    status("R7 still sticky");

    // random transfers
    for (int n = 0; n < 24; n++) begin
      logic [7:0] r = 8'($urandom);
      xfer(r[0], r[1], r[2], 8'($urandom_range(0, 3)), 8'($urandom), 8'($urandom),
           8'($urandom), (r[5:3] == 3'd0) ? 1 : 0, r[7:6] != 2'd0);
      status("R6 idle random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule